// File: doc/BRIEF.md
# Triple Match Timer Peripheral

This peripheral holds three independent 32-bit timers behind a simple word-wide register bus. Each timer owns a counter that software can read and overwrite, a reload value, and two compare values. A single packed control word turns each timer on, chooses whether it advances on every bus-clock cycle or only on a synchronous external tick pulse, and decides whether its wrap event may be recorded. One global bit in that word sets the count direction for all three timers.

Each timer produces three event kinds: compare 1 hit, compare 2 hit and wrap. Events are latched in a sticky status word that software clears by writing ones. A mask word keeps chosen status bits off the single combined interrupt line without stopping them being recorded. A typical use runs one timer free with an all-ones reload as a wall clock and a second timer as a programmable event source.

Reads are combinational from the current address. Writes take effect at the next rising clock edge.

Top module: `tri_match_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The byte-offset map reads back what was written. Timer k (k = 0, 1, 2) has its counter at 0x10*k, its reload at 0x10*k+4, compare 1 at 0x10*k+8 and compare 2 at 0x10*k+0xC. The control word is at 0x30 and holds 10 bits. Status is at 0x34 and mask is at 0x38, each holding 9 bits. Unused upper bits read zero.
- R3: In the control word, timer k uses bit 3k as enable and bit 3k+1 as source select (0 = every clock, 1 = `extTick[k]`). A timer advances only on a cycle where it is enabled and its source is active.
- R4: With control bit 9 clear, an advancing timer decrements. When it advances at zero, it loads its reload value and raises a wrap event in that cycle.
- R5: With control bit 9 set, an advancing timer increments. When it advances at all ones, it loads its reload value and raises a wrap event.
- R6: A bus write to a counter replaces its value and overrides advancing in that cycle. That timer raises no event in that cycle.
- R7: On an advancing cycle where the counter equals compare 1 or compare 2, status bit 3k or 3k+1 is set.
- R8: A wrap event sets status bit 3k+2 only when control bit 3k+2 is set.
- R9: Status bits are sticky and are cleared by writing 1 to them at 0x34. An event in the same cycle as the clear leaves its bit set.
- R10: `irq` is high exactly when some status bit is set whose mask bit is clear. Masked bits are still recorded.
- R11: Offsets with nonzero low two bits, and offsets 0x3C and above, read zero. Writes to them change nothing.
- R12: A timer whose enable bit is clear keeps its counter unchanged, while the other timers keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the current address |
| addr | input | 8 | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| extTick | input | 3 | Per-timer synchronous single-cycle tick pulses |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The hardest state to reach is a software clear of the status word that lands in the same cycle as a new event on the bit being cleared. The event must win that collision. To reach it, the stimulus gives a running timer a very short reload period and writes all ones to the status word on every cycle for a stretch, so compare and wrap events keep colliding with clears. Irregular external tick timing is reached with per-timer pulse trains of co-prime periods, which lets source selection, freezing and wrap be seen out of step with one another.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  localparam int NUM_TMR   = 3;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int BANK_B    = 16;
  localparam int CTRL_OFS  = NUM_TMR * BANK_B;
  localparam int STAT_OFS  = CTRL_OFS + 4;
  localparam int MASK_OFS  = CTRL_OFS + 8;
  localparam int END_OFS   = CTRL_OFS + 12;
  localparam int EVT_W     = 3 * NUM_TMR;
  localparam int CTRL_W    = EVT_W + 1;
  localparam int DIR_BIT   = EVT_W;

  // strobes from register control to the timer datapath
  typedef struct packed {
    logic [NUM_TMR-1:0] cntWr;
    logic [NUM_TMR-1:0] rldWr;
    logic [NUM_TMR-1:0] m1Wr;
    logic [NUM_TMR-1:0] m2Wr;
    logic [NUM_TMR-1:0] advance;
    logic               countUp;
    logic [DATA_W-1:0]  data;
  } tmtStrobe_t;
endpackage

// File: rtl/tmt_timer_unit.sv
module tmt_timer_unit
  import tmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntWr,
  input  logic              rldWr,
  input  logic              m1Wr,
  input  logic              m2Wr,
  input  logic              advance,
  input  logic              countUp,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] rld,
  output logic [DATA_W-1:0] m1,
  output logic [DATA_W-1:0] m2,
  output logic              evtM1,
  output logic              evtM2,
  output logic              evtOvf
);
  logic atEnd;
  logic stepOk;

  assign atEnd  = countUp ? (cnt == {DATA_W{1'b1}}) : (cnt == '0);
  // a software counter write pre-empts the step and its events
  assign stepOk = advance && !cntWr;
  assign evtOvf = stepOk && atEnd;
  assign evtM1  = stepOk && (cnt == m1);
  assign evtM2  = stepOk && (cnt == m2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cntWr) begin
      cnt <= wrData;
    end else if (stepOk) begin
      if (atEnd)        cnt <= rld;
      else if (countUp) cnt <= cnt + 1'b1;
      else              cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rld <= '0;
      m1  <= '0;
      m2  <= '0;
    end else begin
      if (rldWr) rld <= wrData;
      if (m1Wr)  m1  <= wrData;
      if (m2Wr)  m2  <= wrData;
    end
  end
endmodule

// File: rtl/tmt_datapath.sv
module tmt_datapath
  import tmt_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  tmtStrobe_t                     strobe,
  output logic [NUM_TMR-1:0][DATA_W-1:0] cntVal,
  output logic [NUM_TMR-1:0][DATA_W-1:0] rldVal,
  output logic [NUM_TMR-1:0][DATA_W-1:0] m1Val,
  output logic [NUM_TMR-1:0][DATA_W-1:0] m2Val,
  output logic [EVT_W-1:0]               rawEvt
);
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    tmt_timer_unit u_unit (
      .clk     (clk),
      .rstN    (rstN),
      .cntWr   (strobe.cntWr[g]),
      .rldWr   (strobe.rldWr[g]),
      .m1Wr    (strobe.m1Wr[g]),
      .m2Wr    (strobe.m2Wr[g]),
      .advance (strobe.advance[g]),
      .countUp (strobe.countUp),
      .wrData  (strobe.data),
      .cnt     (cntVal[g]),
      .rld     (rldVal[g]),
      .m1      (m1Val[g]),
      .m2      (m2Val[g]),
      .evtM1   (rawEvt[3*g]),
      .evtM2   (rawEvt[3*g+1]),
      .evtOvf  (rawEvt[3*g+2])
    );
  end
endmodule

// File: rtl/tmt_ctrl.sv
module tmt_ctrl
  import tmt_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [NUM_TMR-1:0]             extTick,
  input  logic [NUM_TMR-1:0][DATA_W-1:0] cntVal,
  input  logic [NUM_TMR-1:0][DATA_W-1:0] rldVal,
  input  logic [NUM_TMR-1:0][DATA_W-1:0] m1Val,
  input  logic [NUM_TMR-1:0][DATA_W-1:0] m2Val,
  input  logic [EVT_W-1:0]               rawEvt,
  output tmtStrobe_t                     strobe,
  output logic [CTRL_W-1:0]              ctrlReg,
  output logic [EVT_W-1:0]               statusReg,
  output logic [EVT_W-1:0]               maskReg,
  output logic [DATA_W-1:0]              rdData,
  output logic                           irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]  wordIdx;
  logic               aligned;
  logic               ctrlHit, statHit, maskHit;
  logic [NUM_TMR-1:0] inBank;
  logic [NUM_TMR-1:0] cntWrV, rldWrV, m1WrV, m2WrV, advV;
  logic [EVT_W-1:0]   gatedEvt;
  logic [EVT_W-1:0]   clearBits;

  assign wordIdx = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign ctrlHit = aligned && (wordIdx == WORD_W'(CTRL_OFS / 4));
  assign statHit = aligned && (wordIdx == WORD_W'(STAT_OFS / 4));
  assign maskHit = aligned && (wordIdx == WORD_W'(MASK_OFS / 4));

  always_comb begin
    for (int t = 0; t < NUM_TMR; t++) begin
      inBank[t]       = aligned && (wordIdx[WORD_W-1:2] == (WORD_W-2)'(t));
      cntWrV[t]       = wrEn && inBank[t] && (wordIdx[1:0] == 2'd0);
      rldWrV[t]       = wrEn && inBank[t] && (wordIdx[1:0] == 2'd1);
      m1WrV[t]        = wrEn && inBank[t] && (wordIdx[1:0] == 2'd2);
      m2WrV[t]        = wrEn && inBank[t] && (wordIdx[1:0] == 2'd3);
      advV[t]         = ctrlReg[3*t] && (ctrlReg[3*t+1] ? extTick[t] : 1'b1);
      gatedEvt[3*t]   = rawEvt[3*t];
      gatedEvt[3*t+1] = rawEvt[3*t+1];
      gatedEvt[3*t+2] = rawEvt[3*t+2] && ctrlReg[3*t+2];
    end
  end

  always_comb begin
    strobe.cntWr   = cntWrV;
    strobe.rldWr   = rldWrV;
    strobe.m1Wr    = m1WrV;
    strobe.m2Wr    = m2WrV;
    strobe.advance = advV;
    strobe.countUp = ctrlReg[DIR_BIT];
    strobe.data    = wrData;
  end

  assign clearBits = (wrEn && statHit) ? wrData[EVT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      statusReg <= '0;
      maskReg   <= '0;
    end else begin
      if (wrEn && ctrlHit) ctrlReg <= wrData[CTRL_W-1:0];
      if (wrEn && maskHit) maskReg <= wrData[EVT_W-1:0];
      // new events override a simultaneous clear
      statusReg <= (statusReg & ~clearBits) | gatedEvt;
    end
  end

  always_comb begin
    rdData = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (inBank[t]) begin
        case (wordIdx[1:0])
          2'd0:    rdData = cntVal[t];
          2'd1:    rdData = rldVal[t];
          2'd2:    rdData = m1Val[t];
          default: rdData = m2Val[t];
        endcase
      end
    end
    if (ctrlHit) rdData[CTRL_W-1:0] = ctrlReg;
    if (statHit) rdData[EVT_W-1:0]  = statusReg;
    if (maskHit) rdData[EVT_W-1:0]  = maskReg;
  end

  assign irq = |(statusReg & ~maskReg);
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer
  import tmt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_TMR-1:0] extTick,
  output logic               irq
);
  tmtStrobe_t                     strobe;
  logic [CTRL_W-1:0]              ctrlReg;
  logic [EVT_W-1:0]               statusReg;
  logic [EVT_W-1:0]               maskReg;
  logic [EVT_W-1:0]               rawEvt;
  logic [NUM_TMR-1:0][DATA_W-1:0] cntVal, rldVal, m1Val, m2Val;

  tmt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .extTick   (extTick),
    .cntVal    (cntVal),
    .rldVal    (rldVal),
    .m1Val     (m1Val),
    .m2Val     (m2Val),
    .rawEvt    (rawEvt),
    .strobe    (strobe),
    .ctrlReg   (ctrlReg),
    .statusReg (statusReg),
    .maskReg   (maskReg),
    .rdData    (rdData),
    .irq       (irq)
  );

  tmt_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cntVal (cntVal),
    .rldVal (rldVal),
    .m1Val  (m1Val),
    .m2Val  (m2Val),
    .rawEvt (rawEvt)
  );
endmodule

// File: rtl/tmt_checker.sv
module tmt_checker
  import tmt_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic                           wrEn,
  input logic [ADDR_W-1:0]              addr,
  input logic                           irq,
  input logic [CTRL_W-1:0]              ctrlReg,
  input logic [EVT_W-1:0]               statusReg,
  input logic [EVT_W-1:0]               maskReg,
  input tmtStrobe_t                     strobe,
  input logic [NUM_TMR-1:0][DATA_W-1:0] cntVal,
  input logic [NUM_TMR-1:0][DATA_W-1:0] rldVal
);
  logic statWr;
  logic badWr;

  assign statWr = wrEn && (addr == ADDR_W'(STAT_OFS));
  assign badWr  = wrEn && ((addr[1:0] != 2'b00) || (addr >= ADDR_W'(END_OFS)));

  // R9
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statWr |=> ((statusReg & $past(statusReg)) == $past(statusReg)));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&maskReg) |-> !irq);

  // R11
  unmapped_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    badWr |=> ($stable(ctrlReg) && $stable(maskReg) && $stable(rldVal)));

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
    // R12
    frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrlReg[3*t] && !strobe.cntWr[t]) |=> $stable(cntVal[t]));

    // R4
    down_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.advance[t] && !strobe.countUp && !strobe.cntWr[t] && (cntVal[t] == '0))
      |=> (cntVal[t] == $past(rldVal[t])));

    // R8
    wrap_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusReg[3*t+2]) |-> $past(ctrlReg[3*t+2]));
  end
endmodule

bind tri_match_timer tmt_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .irq       (irq),
  .ctrlReg   (ctrlReg),
  .statusReg (statusReg),
  .maskReg   (maskReg),
  .strobe    (strobe),
  .cntVal    (cntVal),
  .rldVal    (rldVal)
);

// File: tb/tri_match_timer_tb.sv
`timescale 1ns/1ps
module tri_match_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [2:0]  extTick = '0;
  logic        irq;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  logic [31:0] mCnt [3];
  logic [31:0] mRld [3];
  logic [31:0] mM1  [3];
  logic [31:0] mM2  [3];
  logic [9:0]  mCtrl = '0;
  logic [8:0]  mStat = '0;
  logic [8:0]  mMask = '0;

  always #4 clk = ~clk;

  tri_match_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .extTick(extTick), .irq(irq)
  );

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    if (a[1:0] != 2'b00 || a >= 8'h3C) return 32'h0;
    if (a < 8'h30) begin
      case (a[3:2])
        2'd0:    return mCnt[a[5:4]];
        2'd1:    return mRld[a[5:4]];
        2'd2:    return mM1[a[5:4]];
        default: return mM2[a[5:4]];
      endcase
    end
    if (a == 8'h30) return {22'h0, mCtrl};
    if (a == 8'h34) return {23'h0, mStat};
    return {23'h0, mMask};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive, optional read check, clock, advance the model, check irq
  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [2:0] ext, input bit chk, input string tag);
    logic [31:0] nCnt [3];
    logic [31:0] nRld [3];
    logic [31:0] nM1  [3];
    logic [31:0] nM2  [3];
    logic [9:0]  nCtrl;
    logic [8:0]  nStat;
    logic [8:0]  nMask;
    logic [8:0]  ev;
    logic        mapped;
    @(negedge clk);
    wrEn = we; addr = a; wrData = d; extTick = ext;
    #1;
    if (chk) check(tag, rdData, modelRead(a), $sformatf("read @%h", a));
    mapped = (a[1:0] == 2'b00) && (a < 8'h3C);
    ev = '0;
    nCtrl = mCtrl; nMask = mMask;
    for (int t = 0; t < 3; t++) begin
      logic adv, cw, up, wrap;
      nCnt[t] = mCnt[t]; nRld[t] = mRld[t]; nM1[t] = mM1[t]; nM2[t] = mM2[t];
      adv = mCtrl[3*t] && (mCtrl[3*t+1] ? ext[t] : 1'b1);
      cw  = we && mapped && (a < 8'h30) && (int'(a[5:4]) == t) && (a[3:2] == 2'd0);
      up  = mCtrl[9];
      if (we && mapped && a < 8'h30 && int'(a[5:4]) == t) begin
        case (a[3:2])
          2'd0: nCnt[t] = d;
          2'd1: nRld[t] = d;
          2'd2: nM1[t]  = d;
          default: nM2[t] = d;
        endcase
      end
      if (adv && !cw) begin
        wrap = up ? (mCnt[t] == 32'hFFFF_FFFF) : (mCnt[t] == 32'h0);
        if (mCnt[t] == mM1[t]) ev[3*t] = 1'b1;
        if (mCnt[t] == mM2[t]) ev[3*t+1] = 1'b1;
        if (wrap && mCtrl[3*t+2]) ev[3*t+2] = 1'b1;
        nCnt[t] = wrap ? mRld[t] : (up ? mCnt[t] + 32'd1 : mCnt[t] - 32'd1);
      end
    end
    if (we && a == 8'h30) nCtrl = d[9:0];
    if (we && a == 8'h38) nMask = d[8:0];
    nStat = (we && a == 8'h34) ? (mStat & ~d[8:0]) : mStat;
    nStat = nStat | ev;
    @(posedge clk);
    #1;
    for (int t = 0; t < 3; t++) begin
      mCnt[t] = nCnt[t]; mRld[t] = nRld[t]; mM1[t] = nM1[t]; mM2[t] = nM2[t];
    end
    mCtrl = nCtrl; mStat = nStat; mMask = nMask;
    // R10: combined interrupt against the model on every clock
    check("R10", {31'h0, irq}, {31'h0, |(mStat & ~mMask)}, "irq");
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 3'b000, 1'b0, "");
  endtask

  task automatic run(input int n, input int kind);
    for (int i = 0; i < n; i++) begin
      logic [2:0] e;
      if (kind == 0)      e = 3'b000;
      else if (kind == 1) e = 3'b111;
      else e = {(i % 5) == 0, (i % 3) == 0, (i % 2) == 0};
      cyc(1'b0, 8'h00, 32'h0, e, 1'b0, "");
    end
  endtask

  task automatic sweep(input string tag);
    for (int o = 0; o < 64; o += 4) cyc(1'b0, 8'(o), 32'h0, 3'b000, 1'b1, tag);
    cyc(1'b0, 8'h01, 32'h0, 3'b000, 1'b1, "R11");
    cyc(1'b0, 8'h32, 32'h0, 3'b000, 1'b1, "R11");
    cyc(1'b0, 8'h80, 32'h0, 3'b000, 1'b1, "R11");
    cyc(1'b0, 8'hFF, 32'h0, 3'b000, 1'b1, "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < 3; t++) begin
      mCnt[t] = '0; mRld[t] = '0; mM1[t] = '0; mM2[t] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    check("R1", {31'h0, irq}, 32'h0, "irq in reset");
    rstN = 1'b1;
    // R1: everything reads zero after reset
    sweep("R1");

    // R2: register map readback with timers idle
    for (int t = 0; t < 3; t++) begin
      wr(8'(16*t),     32'hA000_0000 + 32'(t));
      wr(8'(16*t + 4), 32'hB100_0010 + 32'(t));
      wr(8'(16*t + 8), 32'hC200_0200 + 32'(t));
      wr(8'(16*t + 12),32'hD300_3000 + 32'(t));
    end
    wr(8'h38, 32'hFFFF_FEAB);
    wr(8'h30, 32'hFFFF_FE00);
    sweep("R2");
    wr(8'h30, 32'h0);
    wr(8'h38, 32'h0);

    // R11: writes to unmapped offsets change nothing
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h31, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    sweep("R11");

    // R4 / R7: down counting with compare and wrap on timer 0
    wr(8'h00, 32'd6); wr(8'h04, 32'd9); wr(8'h08, 32'd3); wr(8'h0C, 32'd8);
    wr(8'h30, 32'h005);
    run(30, 0);
    sweep("R4");
    sweep("R7");

    // R8: wrap not recorded when its interrupt enable is clear
    wr(8'h34, 32'h1FF);
    wr(8'h08, 32'hFFFF_0000); wr(8'h0C, 32'hFFFF_0001);
    wr(8'h30, 32'h001);
    run(30, 0);
    sweep("R8");

    // R9: clear every cycle while short-period events keep firing
    wr(8'h04, 32'd2); wr(8'h08, 32'd1); wr(8'h30, 32'h005);
    for (int i = 0; i < 24; i++) cyc(1'b1, 8'h34, 32'h1FF, 3'b000, 1'b0, "");
    sweep("R9");
    wr(8'h34, 32'h004);
    sweep("R9");

    // R10: masking hides status from irq but recording continues
    wr(8'h38, 32'h1FF);
    run(15, 0);
    sweep("R10");
    wr(8'h38, 32'h000);
    run(3, 0);

    // R5: up counting through all ones
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h1FF);
    wr(8'h00, 32'hFFFF_FFFD); wr(8'h04, 32'd4); wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h30, 32'h205);
    run(15, 0);
    sweep("R5");

    // R3: timer 1 on the external tick, timer 2 on the clock
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h1FF);
    wr(8'h10, 32'd20); wr(8'h14, 32'd25); wr(8'h18, 32'd12); wr(8'h1C, 32'd3);
    wr(8'h20, 32'd40); wr(8'h24, 32'd40); wr(8'h28, 32'd17); wr(8'h2C, 32'd0);
    wr(8'h30, 32'h178);
    run(60, 2);
    sweep("R3");

    // R12: freeze timer 1 while timer 2 keeps running
    wr(8'h30, 32'h140);
    run(40, 2);
    sweep("R12");

    // R6: counter writes pre-empt stepping and suppress that cycle's events
    wr(8'h34, 32'h1FF);
    wr(8'h28, 32'd0);
    for (int i = 0; i < 10; i++) wr(8'h20, 32'd0);
    sweep("R6");
    run(5, 1);
    sweep("R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule